// File: doc/BRIEF.md
# Power-On and Undervoltage Reset Controller

This block produces the chip's active-low system reset. After a power-on event it keeps reset asserted until the clock oscillator reports that it is running, and then for a fixed number of further clock cycles so that logic starts from a settled supply. A watchdog request and an undervoltage comparator can both pull reset low again while the chip is running. When either of them lets go, reset stays low for the same stretch before it is released.

The undervoltage detector is set up through an 8-bit configuration register that takes only one write per power-on. One field picks which comparator trip range (3 V or 5 V) applies. Another field powers the detector down. A third field chooses what a low supply does: it can assert reset, or it can only raise a flag that software polls in the status register. The analog comparators and the oscillator are outside the block and reach it as digital inputs.

Top module: `rst_ctrl`

## Requirements
- R1: After `por_n` is released, `rst_n` stays 0 while `osc_ready` is 0. Once `osc_ready` is 1, `rst_n` rises after exactly STRETCH (default 4096) rising clock edges.
- R2: While undervoltage reset is active and the selected comparator input is 1, `rst_n` is 0. It goes low on the third rising edge after the input rises.
- R3: Configuration bit 5 (undervoltage-reset disable) and bit 4 (detector power-down) enable their function when 0. Both reset to 0, so after power-on a low 3 V comparator causes a reset.
- R4: Configuration bit 0 selects the 5 V comparator (`vlow_5v`) when 1 and the 3 V comparator (`vlow_3v`) when 0. It resets to 0. The comparator that is not selected has no effect.
- R5: Only the first configuration write after `por_n` is released takes effect. Later writes leave `cfg_rd` unchanged until the next power-on.
- R6: When bit 4 is 0 and bit 5 is 1, a low selected comparator sets `status[0]` to 1 and leaves `rst_n` at 1. When bit 4 is 1, neither the flag nor reset responds.
- R7: When the undervoltage condition clears, reset stays low for the full stretch. `rst_n` rises on the 4098th rising edge after the comparator input falls.
- R8: A one-cycle `wdog_req` pulse pulls `rst_n` low after the next edge, and `rst_n` rises STRETCH edges after that.
- R9: `cfg_rd` shows the stored bits 0, 4, 5 and 6 (bit 6 is an enable-in-stop bit that is stored only). All other bits of `cfg_rd` and bits 7:1 of `status` read 0.
- R10: Each comparator input passes through a two-flop synchronizer, so `status[0]` is still 0 after the first edge and is 1 after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock from the oscillator |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| osc_ready | input | 1 | Oscillator start-up complete, synchronous to clk |
| vlow_3v | input | 1 | Asynchronous supply-low output of the 3 V comparator |
| vlow_5v | input | 1 | Asynchronous supply-low output of the 5 V comparator |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| wdog_req | input | 1 | Watchdog reset request |
| rst_n | output | 1 | System reset, active low |
| cfg_rd | output | 8 | Configuration register readback |
| status | output | 8 | Status register; bit 0 is the polled undervoltage flag |

## Verification
The assertions assume that `osc_ready`, `cfg_we` and `wdog_req` are synchronous to `clk`, and that the comparator inputs stay stable long enough for the two-flop synchronizer to capture them. The stimulus changes every input only on the falling clock edge. It holds each comparator level for at least three cycles, and it raises `osc_ready` only after power-on has been released. The sweep covers every combination of the range, power and reset-enable bits against all four comparator input patterns.

// File: rtl/rst_ctrl.sv
module rst_ctrl #(
  parameter int STRETCH = 4096
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       osc_ready,
  input  logic       vlow_3v,
  input  logic       vlow_5v,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       wdog_req,
  output logic       rst_n,
  output logic [7:0] cfg_rd,
  output logic [7:0] status
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] DONE = CW'(STRETCH);
  localparam logic [7:0] CFG_MASK = 8'h71;

  logic [1:0]    sync3, sync5;
  logic [7:0]    cfg;
  logic          locked;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sync3 <= '0;
      sync5 <= '0;
    end else begin
      sync3 <= {sync3[0], vlow_3v};
      sync5 <= {sync5[0], vlow_5v};
    end
  end

  wire vlow_sel = cfg[0] ? sync5[1] : sync3[1];
  wire det_on   = ~cfg[4];
  wire uv_hold  = det_on & ~cfg[5] & vlow_sel;
  wire uv_flag  = det_on &  cfg[5] & vlow_sel;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg    <= '0;
      locked <= 1'b0;
    end else if (cfg_we && !locked) begin
      cfg    <= cfg_wdata & CFG_MASK;
      locked <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      cnt <= '0;
    else if (uv_hold || wdog_req)
      cnt <= '0;
    else if (osc_ready && cnt != DONE)
      cnt <= cnt + 1'b1;
  end

  assign rst_n  = (cnt == DONE);
  assign cfg_rd = cfg;
  assign status = {7'b0, uv_flag};

  assert_osc_gate_R1: assert property (@(posedge clk) disable iff (!por_n)
    (!osc_ready && !rst_n) |=> !rst_n);

  assert_release_after_ready_R1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n) |-> $past(osc_ready));

  assert_uv_hold_R2: assert property (@(posedge clk) disable iff (!por_n)
    uv_hold |=> !rst_n);

  assert_write_once_R5: assert property (@(posedge clk) disable iff (!por_n)
    (locked && cfg_we) |=> $stable(cfg_rd));

  assert_flag_no_reset_R6: assert property (@(posedge clk) disable iff (!por_n)
    (status[0] && !wdog_req && rst_n) |=> rst_n);

  assert_wdog_R8: assert property (@(posedge clk) disable iff (!por_n)
    wdog_req |=> !rst_n);

  assert_layout_R9: assert property (@(posedge clk) disable iff (!por_n)
    ((cfg_rd & ~CFG_MASK) == 8'h00) && (status[7:1] == 7'b0));
endmodule

// File: tb/test_rst_ctrl.sv
module test_rst_ctrl;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       osc_ready = 1'b0;
  logic       vlow_3v = 1'b0;
  logic       vlow_5v = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       wdog_req = 1'b0;
  logic       rst_n;
  logic [7:0] cfg_rd;
  logic [7:0] status;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rst_ctrl #(.STRETCH(4096)) i_rst_ctrl (
    .clk(clk), .por_n(por_n), .osc_ready(osc_ready),
    .vlow_3v(vlow_3v), .vlow_5v(vlow_5v),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .wdog_req(wdog_req),
    .rst_n(rst_n), .cfg_rd(cfg_rd), .status(status)
  );

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic power_on();
    @(negedge clk);
    por_n = 1'b0; osc_ready = 1'b0; vlow_3v = 1'b0; vlow_5v = 1'b0;
    cfg_we = 1'b0; wdog_req = 1'b0;
    cycles(2);
    por_n = 1'b1;
  endtask

  initial begin
    for (int c = 0; c < 8; c++) begin
      logic b0, b4, b5, hold, flag, sel;
      logic [7:0] wval, expc;
      b0 = c[0]; b4 = c[1]; b5 = c[2];
      wval = 8'h8E | {7'b0, b0} | (b4 ? 8'h10 : 8'h00) | (b5 ? 8'h20 : 8'h00)
             | (c[0] ? 8'h40 : 8'h00);
      expc = wval & 8'h71;
      power_on();
      chk("R3 reset cfg", int'(cfg_rd), 0);
      chk("R1 reset rst_n", int'(rst_n), 0);
      chk("R9 reset status", int'(status), 0);
      cycles(20);
      chk("R1 no osc", int'(rst_n), 0);
      cfg_we = 1'b1; cfg_wdata = wval;
      cycles(1);
      cfg_wdata = ~wval;
      cycles(1);
      cfg_we = 1'b0;
      chk("R5 R9 first write kept", int'(cfg_rd), int'(expc));
      osc_ready = 1'b1;
      cycles(4095);
      chk("R1 stretch low", int'(rst_n), 0);
      cycles(1);
      chk("R1 stretch release", int'(rst_n), 1);
      for (int v = 0; v < 4; v++) begin
        vlow_3v = v[0]; vlow_5v = v[1];
        sel  = b0 ? v[1] : v[0];
        hold = !b4 && !b5 && sel;
        flag = !b4 && b5 && sel;
        if (flag) begin
          cycles(1);
          chk("R10 sync stage 1", int'(status[0]), 0);
          cycles(1);
          chk("R10 sync stage 2", int'(status[0]), 1);
          cycles(1);
        end else begin
          cycles(3);
        end
        chk("R2 R4 R3 reset level", int'(rst_n), int'(!hold));
        chk("R6 R4 flag", int'(status), int'(flag));
        vlow_3v = 1'b0; vlow_5v = 1'b0;
        if (hold) begin
          cycles(4097);
          chk("R7 restretch low", int'(rst_n), 0);
          cycles(1);
          chk("R7 restretch release", int'(rst_n), 1);
        end else begin
          cycles(3);
          chk("R6 stays out of reset", int'(rst_n), 1);
        end
      end
    end
    wdog_req = 1'b1;
    cycles(1);
    wdog_req = 1'b0;
    chk("R8 wdog asserts", int'(rst_n), 0);
    cycles(4095);
    chk("R8 wdog stretch low", int'(rst_n), 0);
    cycles(1);
    chk("R8 wdog release", int'(rst_n), 1);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule